// File: doc/BRIEF.md
# Two-Point Gain and Offset Coefficient Engine

This block derives the two coefficients used by a linear converter-correction stage, from two averaged raw readings of a known high reference (ideally three quarters of full scale) and a known low reference (ideally one quarter of full scale). A start pulse launches a sequential engine. It divides the ideal reference span by the measured span one quotient bit per cycle, which gives an unsigned fixed-point gain. In the same loop it builds the product of that gain and the raw high reading. A last step turns the product into a signed offset that includes the half-LSB centring term.

The result is announced with a one-cycle done pulse that carries an error flag. The flag is raised when the readings are out of order, when the gain would not fit in its field, or when either coefficient falls outside caller-supplied limits. Surrounding logic uses this flag to decide whether to commit the coefficients. Between done pulses the outputs stay unchanged.

Top module: `cal_coef_engine`

## Requirements
- R1: After reset, done_o, busy_o and err_o are 0, and gain_o and offset_o are 0.
- R2: With d = ref_hi_i − ref_lo_i, the gain is floor(2^27 / d) as a 15-bit unsigned value. It has 14 fractional bits, so 16384 means 1.0.
- R3: The offset is 12288 − floor(gain × ref_hi_i / 2^14) − 2, reported as a 14-bit two's-complement field. For ref_hi_i = 12263 and ref_lo_i = 4109 this gives gain 16460 and offset −33.
- R4: If d ≤ 4096, the gain would not fit. The engine stops after its first iteration and gives done_o with err_o = 1 and both coefficients 0. done_o is seen 2 clock edges after the accepting edge is counted as edge 1.
- R5: If ref_hi_i ≤ ref_lo_i when start is accepted, done_o and err_o rise at that same accepting edge. No iteration is run, and both coefficients are 0.
- R6: The gain limits gain_min_i and gain_max_i are sampled at the accepting edge. A gain outside [gain_min_i, gain_max_i] sets err_o, and both coefficients are still reported.
- R7: The offset limit off_lim_i is sampled at the accepting edge. If the untruncated offset lies outside [−off_lim_i, +off_lim_i], err_o is set and both coefficients are still reported.
- R8: For an ordered pair, busy_o is high from the accepting edge until the result. done_o rises on the 17th clock edge, counting the accepting edge as the 1st.
- R9: While busy_o is high, a start pulse has no effect. No extra result is produced and the running result is unchanged.
- R10: done_o is high for one cycle per result and never together with busy_o. gain_o, offset_o and err_o change only at edges that raise done_o.
- R11: A start given in the cycle where done_o is high is accepted, so results can follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, accepted when idle |
| ref_hi_i | input | 14 | Raw reading of the high reference |
| ref_lo_i | input | 14 | Raw reading of the low reference |
| gain_min_i | input | 15 | Lowest acceptable gain, gain units |
| gain_max_i | input | 15 | Highest acceptable gain, gain units |
| off_lim_i | input | 13 | Largest acceptable offset magnitude |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Result invalid or out of limits |
| gain_o | output | 15 | Gain coefficient |
| offset_o | output | 14 | Offset coefficient, two's complement |

## Verification
Result delivery and start acceptance can land in the same cycle. The bench provokes this by raising the next start in the very cycle where done is seen. It does so once with a valid pair and once with an out-of-order pair, and the second case makes done high in two consecutive cycles. Each of those cycles is judged as a separate result from the scoreboard queue, checking values and latency. A start raised in the middle of a run must not add a queue entry, and any unexpected done is reported as a failure.

// File: rtl/cal_coef_pkg.sv
package cal_coef_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cal_state_e;

  // ideal code of a reference at quarter-scale position 'quarters'
  function automatic int unsigned ideal_code(int unsigned raw_w, int unsigned quarters);
    return quarters << (raw_w - 2);
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_coef_pkg::*;
#(
  parameter int ITER = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ordered_i,
  input  logic ovf_i,
  output logic accept_o,
  output logic load_o,
  output logic reject_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(ITER);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

  cal_state_e state_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign load_o   = accept_o && ordered_i;
  assign reject_o = accept_o && !ordered_i;
  assign step_o   = (state_q == ST_RUN);
  assign fin_o    = (state_q == ST_FIN);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (ovf_i)               state_q <= ST_IDLE;
          else if (cnt_q == LAST)  state_q <= ST_FIN;
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cal_div_mac.sv
module cal_div_mac #(
  parameter int RAW_W  = 14,
  parameter int GAIN_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    step_i,
  input  logic [RAW_W-1:0]        hi_i,
  input  logic [RAW_W-1:0]        lo_i,
  output logic [GAIN_W-1:0]       quot_o,
  output logic [GAIN_W+RAW_W-1:0] prod_o,
  output logic                    ovf_o
);
  localparam int REM_W  = RAW_W + 1;
  localparam int ACC_W  = GAIN_W + RAW_W;
  localparam logic [REM_W-1:0] SPAN = REM_W'(1) << (RAW_W - 1);

  logic [REM_W-1:0]  rem_q;
  logic [RAW_W-1:0]  div_q;
  logic [RAW_W-1:0]  hi_q;
  logic [GAIN_W-1:0] quot_q;
  logic [ACC_W-1:0]  acc_q;

  // one restoring-division step; also reports a second fit (overflow)
  function automatic logic [REM_W:0] div_step(input logic [REM_W-1:0] rem,
                                              input logic [RAW_W-1:0] dv);
    logic [REM_W-1:0] left;
    logic take;
    take = rem >= {1'b0, dv};
    left = take ? rem - {1'b0, dv} : rem;
    return {take, left};
  endfunction

  logic [REM_W:0]   step_res;
  logic             take_w;
  logic [REM_W-1:0] left_w;

  assign step_res = div_step(rem_q, div_q);
  assign take_w   = step_res[REM_W];
  assign left_w   = step_res[REM_W-1:0];
  assign ovf_o    = step_i && take_w && (left_w >= {1'b0, div_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      div_q  <= '0;
      hi_q   <= '0;
      quot_q <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      rem_q  <= SPAN;
      div_q  <= hi_i - lo_i;
      hi_q   <= hi_i;
      quot_q <= '0;
      acc_q  <= '0;
    end else if (step_i) begin
      rem_q  <= {left_w[REM_W-2:0], 1'b0};
      quot_q <= {quot_q[GAIN_W-2:0], take_w};
      acc_q  <= {acc_q[ACC_W-2:0], 1'b0} + (take_w ? ACC_W'(hi_q) : '0);
    end
  end

  assign quot_o = quot_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/cal_post.sv
module cal_post
  import cal_coef_pkg::*;
#(
  parameter int RAW_W  = 14,
  parameter int GAIN_W = 15,
  parameter int HALF   = 2
) (
  input  logic [GAIN_W-1:0]       quot_i,
  input  logic [GAIN_W+RAW_W-1:0] prod_i,
  input  logic [GAIN_W-1:0]       gmin_i,
  input  logic [GAIN_W-1:0]       gmax_i,
  input  logic [RAW_W-2:0]        olim_i,
  output logic [RAW_W-1:0]        offset_o,
  output logic                    lim_err_o
);
  localparam int OW = GAIN_W + 2;
  localparam logic signed [OW-1:0] IDEAL_HI = OW'(ideal_code(RAW_W, 3));

  function automatic logic signed [OW-1:0] offset_full(input logic [GAIN_W+RAW_W-1:0] prod);
    logic [GAIN_W-1:0] scaled;
    scaled = prod[GAIN_W+RAW_W-1:RAW_W];
    return IDEAL_HI - $signed({2'b00, scaled}) - OW'(HALF);
  endfunction

  logic signed [OW-1:0] off_w;
  logic signed [OW-1:0] lim_w;
  logic gain_bad, off_bad;

  assign off_w     = offset_full(prod_i);
  assign lim_w     = $signed({{(OW-RAW_W+1){1'b0}}, olim_i});
  assign gain_bad  = (quot_i < gmin_i) || (quot_i > gmax_i);
  assign off_bad   = (off_w > lim_w) || (off_w < -lim_w);
  assign lim_err_o = gain_bad || off_bad;
  assign offset_o  = off_w[RAW_W-1:0];
endmodule

// File: rtl/cal_coef_engine.sv
module cal_coef_engine #(
  parameter int RAW_W = 14,
  parameter int HALF  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RAW_W-1:0]   ref_hi_i,
  input  logic [RAW_W-1:0]   ref_lo_i,
  input  logic [RAW_W:0]     gain_min_i,
  input  logic [RAW_W:0]     gain_max_i,
  input  logic [RAW_W-2:0]   off_lim_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [RAW_W:0]     gain_o,
  output logic [RAW_W-1:0]   offset_o
);
  localparam int GAIN_W = RAW_W + 1;
  localparam int ACC_W  = GAIN_W + RAW_W;

  // named internal events for the checker
  logic accept_evt, load_evt, reject_evt, step_evt, fin_evt, ovf_evt;

  logic [GAIN_W-1:0] quot_w;
  logic [ACC_W-1:0]  prod_w;
  logic [RAW_W-1:0]  off_w;
  logic              lim_err_w;

  logic [GAIN_W-1:0] gmin_q, gmax_q;
  logic [RAW_W-2:0]  olim_q;

  cal_ctrl #(.ITER(GAIN_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ordered_i(ref_hi_i > ref_lo_i), .ovf_i(ovf_evt),
    .accept_o(accept_evt), .load_o(load_evt), .reject_o(reject_evt),
    .step_o(step_evt), .fin_o(fin_evt), .busy_o(busy_o)
  );

  cal_div_mac #(.RAW_W(RAW_W), .GAIN_W(GAIN_W)) dm_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .step_i(step_evt),
    .hi_i(ref_hi_i), .lo_i(ref_lo_i),
    .quot_o(quot_w), .prod_o(prod_w), .ovf_o(ovf_evt)
  );

  cal_post #(.RAW_W(RAW_W), .GAIN_W(GAIN_W), .HALF(HALF)) post_i (
    .quot_i(quot_w), .prod_i(prod_w),
    .gmin_i(gmin_q), .gmax_i(gmax_q), .olim_i(olim_q),
    .offset_o(off_w), .lim_err_o(lim_err_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmin_q <= '0;
      gmax_q <= '0;
      olim_q <= '0;
    end else if (load_evt) begin
      gmin_q <= gain_min_i;
      gmax_q <= gain_max_i;
      olim_q <= off_lim_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      gain_o   <= '0;
      offset_o <= '0;
    end else begin
      done_o <= reject_evt || ovf_evt || fin_evt;
      if (reject_evt || ovf_evt) begin
        err_o    <= 1'b1;
        gain_o   <= '0;
        offset_o <= '0;
      end else if (fin_evt) begin
        err_o    <= lim_err_w;
        gain_o   <= quot_w;
        offset_o <= off_w;
      end
    end
  end
endmodule

// File: rtl/cal_coef_chk.sv
module cal_coef_chk #(
  parameter int RAW_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [RAW_W:0]   gain_o,
  input logic [RAW_W-1:0] offset_o,
  input logic             load_evt,
  input logic             reject_evt,
  input logic             ovf_evt
);
  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(gain_o) && $stable(offset_o) && $stable(err_o)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (done_o && err_o && gain_o == '0 && offset_o == '0));

  assert_reject_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (done_o && err_o && !busy_o && gain_o == '0));

  assert_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (busy_o && !done_o));

  assert_gain_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (gain_o >= ((RAW_W+1)'(1) << (RAW_W - 1))));
endmodule

bind cal_coef_engine cal_coef_chk #(.RAW_W(RAW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .gain_o(gain_o), .offset_o(offset_o), .load_evt(load_evt),
  .reject_evt(reject_evt), .ovf_evt(ovf_evt)
);

// File: tb/cal_coef_engine_tb_top.sv
module cal_coef_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [13:0] ref_hi_i = '0, ref_lo_i = '0;
  logic [14:0] gain_min_i = '0, gain_max_i = '0;
  logic [12:0] off_lim_i = '0;
  logic busy_o, done_o, err_o;
  logic [14:0] gain_o;
  logic [13:0] offset_o;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [14:0] g;
    logic [13:0] o;
    logic        e;
  } exp_t;
  exp_t expq[$];
  string tagq[$];

  always #5 clk = ~clk;

  cal_coef_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_hi_i(ref_hi_i),
    .ref_lo_i(ref_lo_i), .gain_min_i(gain_min_i), .gain_max_i(gain_max_i),
    .off_lim_i(off_lim_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .gain_o(gain_o), .offset_o(offset_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model: the requirements restated with plain integer arithmetic
  function automatic exp_t model(input int hi, input int lo, input int gmin,
                                 input int gmax, input int olim);
    exp_t r;
    longint d, g, p, o;
    d = hi - lo;
    r = '0;
    if (d <= 0 || d <= 4096) begin
      r.e = 1'b1;
      return r;
    end
    g = (longint'(1) << 27) / d;
    p = (g * hi) >>> 14;
    o = 12288 - p - 2;
    r.g = g[14:0];
    r.o = o[13:0];
    r.e = (g < gmin) || (g > gmax) || (o > olim) || (o < -olim);
    return r;
  endfunction

  // driver: one start pulse, expectation pushed to the scoreboard
  task automatic launch(input int hi, input int lo, input int gmin, input int gmax,
                        input int olim, input string tag);
    ref_hi_i = 14'(hi); ref_lo_i = 14'(lo);
    gain_min_i = 15'(gmin); gain_max_i = 15'(gmax); off_lim_i = 13'(olim);
    expq.push_back(model(hi, lo, gmin, gmax, olim));
    tagq.push_back(tag);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic await_done(input int n0, input int exp_lat, input string tag);
    int n;
    n = n0;
    while (!done_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_lat, {tag, " latency"}, n, exp_lat);
  endtask

  // monitor: pops and compares on every done
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(gain_o == e.g, {t, " gain"}, gain_o, e.g);
        check(offset_o == e.o, {t, " offset"}, $signed(offset_o), $signed(e.o));
        check(err_o == e.e, {t, " err"}, err_o, e.e);
      end
    end
  end

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !busy_o && !err_o, "R1 reset flags", {done_o, busy_o, err_o}, 0);
    check(gain_o == 0 && offset_o == 0, "R1 reset coefs", gain_o, 0);

    // R2 R3 worked example, latency R8
    launch(12263, 4109, 15000, 18000, 200, "R2_R3 example");
    check(busy_o, "R8 busy", busy_o, 1);
    await_done(1, 17, "R8 example");
    @(negedge clk);
    check(!done_o, "R10 single pulse", done_o, 0);
    repeat (3) @(negedge clk);
    check(gain_o == 16460 && $signed(offset_o) == -33, "R10 hold", gain_o, 16460);

    // R6 gain limit
    launch(12263, 4109, 15000, 16000, 200, "R6 gain high");
    await_done(1, 17, "R6");
    launch(12263, 4109, 16461, 18000, 200, "R6 gain low");
    await_done(1, 17, "R6b");

    // R7 offset limit boundary
    launch(12263, 4109, 0, 32767, 32, "R7 off over");
    await_done(1, 17, "R7");
    launch(12263, 4109, 0, 32767, 33, "R7 off edge");
    await_done(1, 17, "R7b");
    launch(4000, 16383, 0, 32767, 8191, "R5 ignore limits");
    await_done(1, 1, "R5");

    // R5 ordering
    launch(5000, 5000, 0, 32767, 8191, "R5 equal");
    await_done(1, 1, "R5 eq");
    @(negedge clk);
    launch(100, 9000, 0, 32767, 8191, "R5 reversed");
    await_done(1, 1, "R5 rev");
    @(negedge clk);

    // R4 overflow boundary
    launch(5000, 904, 0, 32767, 8191, "R4 span4096");
    await_done(1, 2, "R4");
    @(negedge clk);
    launch(8193, 4096, 0, 32767, 8191, "R2 span4097");
    await_done(1, 17, "R2 span4097");
    launch(16383, 0, 0, 32767, 8191, "R2 full span");
    await_done(1, 17, "R2 full");
    launch(12400, 4000, 0, 32767, 8191, "R3 other");
    await_done(1, 17, "R3 other");

    // R9 start during busy is ignored
    launch(12263, 4109, 15000, 18000, 200, "R9 first");
    repeat (4) @(negedge clk);
    ref_hi_i = 14'd9000; ref_lo_i = 14'd1000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; ref_hi_i = 14'd12263; ref_lo_i = 14'd4109;
    await_done(6, 17, "R9");
    repeat (25) @(negedge clk);
    check(expq.size() == 0, "R9 no extra result", expq.size(), 0);

    // R11 start in done cycle: valid then reversed then valid
    launch(12263, 4109, 15000, 18000, 200, "R11 a");
    await_done(1, 17, "R11 a");
    launch(3000, 3000, 0, 32767, 8191, "R11 b");
    check(done_o, "R11 reject back-to-back", done_o, 1);
    await_done(1, 1, "R11 b");
    launch(12400, 4000, 0, 32767, 8191, "R11 c");
    await_done(1, 17, "R11 c");
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R11 queue drained", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule